// File: doc/BRIEF.md
# Six-Digit Multiplexed Seven-Segment Display Scanner

This block drives a bank of six common-cathode seven-segment digits that share one set of segment lines (a to g plus the decimal point). Each digit has its own select line, which is active low. The block takes six 4-bit BCD values and one decimal-point flag per digit. It shows them one digit at a time, giving each digit a fixed dwell before moving on. Persistence of vision then makes all six digits appear lit together. A typical use is a clock face showing hours, minutes and seconds.

For each scan slot the block picks the digit value for that slot and decodes it into an active-high segment pattern. It updates the segment lines, the decimal point and the select lines on the same clock edge, so a stale pattern never appears on a newly selected digit. The dwell is set by a clock divider parameter. With the default value it is 1 ms at 125 MHz, and a test can shorten it.

Top module: `seg_scan6`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every select line is high (no digit lit), and `seg_out` and `dp_out` are all zero.
- R2: From the first rising edge with `rst` low onward, exactly one bit of `dig_sel_n` is low.
- R3: Digit 0 (bits [3:0] of `digit_bcd`, select bit 0) is shown first after reset. The scan then moves to digit 1, 2, ... up to NUM_DIGITS-1 and wraps back to digit 0.
- R4: Each digit stays selected for exactly SLOT_CYCLES clocks. The default is 125000, which is 1 ms at 125 MHz.
- R5: Codes 0 to 9 are decoded to active-high segments, with bit 0 = a through bit 6 = g: 0→0x3F, 1→0x06, 2→0x5B, 3→0x4F, 4→0x66, 5→0x6D, 6→0x7D, 7→0x07, 8→0x7F, 9→0x6F.
- R6: Codes 10 to 15 drive all seven segments off (0x00).
- R7: `dp_out` equals the `dp_in` bit of the selected digit, active high.
- R8: All outputs are registered with one cycle of latency. Segment data, decimal point and select lines update on the same edge, from the inputs sampled on the previous edge.
- R9: Changing the value of a digit that is not selected has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_bcd | input | 4*NUM_DIGITS | Packed digit codes; digit i is in bits [4i+3:4i] |
| dp_in | input | NUM_DIGITS | Decimal-point flag per digit |
| seg_out | output | 7 | Segments a..g (bit 0 = a), active high |
| dp_out | output | 1 | Decimal point, active high |
| dig_sel_n | output | NUM_DIGITS | Digit selects, active low |

## Verification
The case that is hardest to reach from the ports is a change to a digit's value while the scan is on a different digit. The block must ignore it, and the output must still pick the change up one cycle after that digit becomes selected. The stimulus shortens the dwell to 8 clocks and waits for the scan to enter digit 0. It then rewrites all other digits in mid-slot and confirms that the segments hold. Random rewrites at arbitrary cycles, together with the blanked codes 10 to 15, cover the latency against the slot boundaries. A reset in the middle of a run confirms that the scan restarts at digit 0.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int SLOT_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/scan_slot_ctr.sv
module scan_slot_ctr #(
  parameter int NUM_DIGITS = 6,
  parameter int SW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [SW-1:0] slot
);
  localparam logic [SW-1:0] LAST = SW'(NUM_DIGITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (advance) begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end
  end
endmodule

// File: rtl/seg_bcd_decode.sv
module seg_bcd_decode
  import seg_scan_pkg::*;
(
  input  bcd_t code,
  output seg_t segs
);
  always_comb begin
    case (code)
      4'd0:    segs = 7'h3F;
      4'd1:    segs = 7'h06;
      4'd2:    segs = 7'h5B;
      4'd3:    segs = 7'h4F;
      4'd4:    segs = 7'h66;
      4'd5:    segs = 7'h6D;
      4'd6:    segs = 7'h7D;
      4'd7:    segs = 7'h07;
      4'd8:    segs = 7'h7F;
      4'd9:    segs = 7'h6F;
      default: segs = 7'h00;
    endcase
  end
endmodule

// File: rtl/seg_scan6.sv
module seg_scan6
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 6,
  parameter int SLOT_CYCLES = 125000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_DIGITS*BCD_W-1:0] digit_bcd,
  input  logic [NUM_DIGITS-1:0]       dp_in,
  output logic [SEG_W-1:0]            seg_out,
  output logic                        dp_out,
  output logic [NUM_DIGITS-1:0]       dig_sel_n
);
  localparam int SW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic          tick;
  logic [SW-1:0] slot;
  bcd_t          cur_code;
  seg_t          cur_segs;
  logic [NUM_DIGITS-1:0] sel_n_next;

  scan_tick_gen #(.SLOT_CYCLES(SLOT_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  scan_slot_ctr #(.NUM_DIGITS(NUM_DIGITS), .SW(SW)) u_slot (
    .clk(clk), .rst(rst), .advance(tick), .slot(slot)
  );

  assign cur_code = digit_bcd[slot*BCD_W +: BCD_W];

  seg_bcd_decode u_dec (
    .code(cur_code), .segs(cur_segs)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
    assign sel_n_next[i] = (slot != SW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_out   <= '0;
      dp_out    <= 1'b0;
      dig_sel_n <= '1;
    end else begin
      seg_out   <= cur_segs;
      dp_out    <= dp_in[slot];
      dig_sel_n <= sel_n_next;
    end
  end
endmodule

// File: rtl/seg_scan6_chk.sv
module seg_scan6_chk #(
  parameter int NUM_DIGITS  = 6,
  parameter int SLOT_CYCLES = 125000
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_DIGITS*4-1:0]   digit_bcd,
  input logic [NUM_DIGITS-1:0]     dp_in,
  input logic [6:0]                seg_out,
  input logic                      dp_out,
  input logic [NUM_DIGITS-1:0]     dig_sel_n
);
  logic                    rst_q;
  logic [NUM_DIGITS-1:0]   sel_q;
  logic [NUM_DIGITS*4-1:0] dig_q;
  logic [NUM_DIGITS-1:0]   dp_q;
  logic [31:0]             hold_cnt;
  int                      idx;
  logic [3:0]              nib;

  function automatic logic [NUM_DIGITS-1:0] rotl(input logic [NUM_DIGITS-1:0] v);
    return {v[NUM_DIGITS-2:0], v[NUM_DIGITS-1]};
  endfunction

  always_comb begin
    idx = 0;
    for (int i = 0; i < NUM_DIGITS; i++) if (!dig_sel_n[i]) idx = i;
    nib = dig_q[idx*4 +: 4];
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    sel_q <= dig_sel_n;
    dig_q <= digit_bcd;
    dp_q  <= dp_in;
    if (rst || dig_sel_n != sel_q) hold_cnt <= '0;
    else hold_cnt <= hold_cnt + 1;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      reset_idle_chk: assert (&dig_sel_n && seg_out == '0 && !dp_out);
    end
  end

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> $countones(~dig_sel_n) == 1);

  // R3
  scan_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && dig_sel_n != sel_q && !(&sel_q)) |-> (~dig_sel_n == rotl(~sel_q)));

  // R4
  dwell_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && dig_sel_n != sel_q && !(&sel_q)) |-> hold_cnt == 32'(SLOT_CYCLES - 1));

  // R6
  blank_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && nib > 4'd9) |-> seg_out == 7'h00);

  // R5
  valid_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && nib <= 4'd9) |-> $countones(seg_out) >= 2);

  // R7
  dp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> dp_out == dp_q[idx]);
endmodule

bind seg_scan6 seg_scan6_chk #(.NUM_DIGITS(NUM_DIGITS), .SLOT_CYCLES(SLOT_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .digit_bcd(digit_bcd), .dp_in(dp_in),
  .seg_out(seg_out), .dp_out(dp_out), .dig_sel_n(dig_sel_n)
);

// File: tb/test_seg_scan6.sv
`timescale 1ns/1ps
module test_seg_scan6;
  localparam int N = 6;
  localparam int T = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*4-1:0] digit_bcd = '0;
  logic [N-1:0]   dp_in = '0;
  logic [6:0]     seg_out;
  logic           dp_out;
  logic [N-1:0]   dig_sel_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_scan6 #(.NUM_DIGITS(N), .SLOT_CYCLES(T)) i_seg_scan6 (
    .clk(clk), .rst(rst), .digit_bcd(digit_bcd), .dp_in(dp_in),
    .seg_out(seg_out), .dp_out(dp_out), .dig_sel_n(dig_sel_n)
  );

  function automatic logic [6:0] pattern(input logic [3:0] c);
    case (c)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // Reference model from requirements R1, R3, R4, R5, R6, R7, R8
  int             k;
  logic [N-1:0]   exp_sel;
  logic [6:0]     exp_seg;
  logic           exp_dp;
  logic [3:0]     exp_code;
  always @(posedge clk) begin
    if (rst) begin
      k <= 0; exp_sel <= '1; exp_seg <= '0; exp_dp <= 1'b0; exp_code <= '0;
    end else begin
      int s;
      s = (k / T) % N;
      exp_sel  <= ~(N'(1) << s);
      exp_code <= digit_bcd[s*4 +: 4];
      exp_seg  <= pattern(digit_bcd[s*4 +: 4]);
      exp_dp   <= dp_in[s];
      k <= k + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(dig_sel_n == exp_sel, "R3 select", dig_sel_n, exp_sel);
    if (!rst && k > 0) chk($countones(~dig_sel_n) == 1, "R2 one select", dig_sel_n, 0);
    chk(seg_out == exp_seg, (exp_code > 9) ? "R6 blank" : "R5 decode", seg_out, exp_seg);
    chk(dp_out == exp_dp, "R7 dp", dp_out, exp_dp);
  endtask

  task automatic step(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (rnd && ($urandom % 4 == 0)) begin
        digit_bcd = {$urandom, $urandom};
        dp_in = N'($urandom);
      end
    end
  endtask

  initial begin
    int seed_dummy;
    int dwell;
    logic [6:0] held;
    seed_dummy = $urandom(32'd20240611);
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(&dig_sel_n, "R1 select idle", dig_sel_n, '1);
    chk(seg_out == 0 && dp_out == 0, "R1 segs off", {dp_out, seg_out}, 0);
    digit_bcd = {4'd0, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9};
    dp_in = 6'b010100;
    rst = 1'b0;
    step(N*T*2 + 3, 0);
    // R6: codes 10..15
    digit_bcd = {4'd15, 4'd14, 4'd13, 4'd12, 4'd11, 4'd10};
    step(N*T + 2, 0);
    digit_bcd = {4'd1, 4'd2, 4'd3, 4'd4, 4'd0, 4'd9};
    dp_in = 6'b101011;
    step(N*T, 0);
    // R4: dwell of digit 1
    while (dig_sel_n[1] !== 1'b0) step(1, 0);
    dwell = 0;
    while (dig_sel_n[1] === 1'b0) begin dwell++; step(1, 0); end
    chk(dwell == T, "R4 dwell", dwell, T);
    // R9: unselected digits changed mid-slot of digit 0
    while (dig_sel_n[0] !== 1'b0) step(1, 0);
    held = seg_out;
    digit_bcd[N*4-1:4] = ~digit_bcd[N*4-1:4];
    step(1, 0);
    chk(seg_out == held, "R9 unselected ignored", seg_out, held);
    // R8: selected digit changed mid-slot, seen one cycle later
    digit_bcd[3:0] = 4'd8;
    step(1, 0);
    chk(seg_out == 7'h7F, "R8 latency", seg_out, 7'h7F);
    // random phase
    step(4000, 1);
    // mid-run reset, R1 and restart at digit 0 (R3)
    rst = 1'b1;
    step(3, 0);
    chk(&dig_sel_n, "R1 select idle mid-run", dig_sel_n, '1);
    rst = 1'b0;
    step(1, 0);
    chk(dig_sel_n == ~N'(1), "R3 restart digit0", dig_sel_n, ~N'(1));
    step(2000, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule